// File: doc/BRIEF.md
# Delayed-Commit Memory Write Buffer

This block sits between a processor memory port and a RAM array whose write data settles too late to be followed at once by a read. A write request from the processor is not sent to the RAM when it arrives. Its address and data are kept in holding registers. The buffered write is carried out only when the next write arrives. In that operation the RAM receives the previously held address and data, and the new request takes their place in the holding registers. Every write therefore reaches the array one write late.

The write strobe comes before the write data. The block accepts a write in one cycle and samples the data in the next cycle. It then loads the address and the data into the holding registers together. Reads go straight to the RAM. The one exception is a read whose address matches the held, uncommitted write: that read is answered from the holding registers, so software always sees the latest value. A flush input pushes the held write out to the RAM and clears it. A busy output marks the cycle of that commit.

Top module: `late_write_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready_o` is 1, and `ram_en_o`, `ram_we_o`, `rsp_valid_o` and `busy_o` are all 0.
- R2: A write is accepted in cycle T when `req_valid_i`, `req_we_i` and `req_ready_o` are all 1. Its data is taken from `req_wdata_i` in cycle T+1, not in cycle T. `req_ready_o` is 0 in cycle T+1.
- R3: A write accepted while no write is held causes no RAM write. This covers the first write after reset and the first write after a flush.
- R4: In cycle T+1 of a write accepted while a write is held, `ram_en_o` and `ram_we_o` are 1, and `ram_addr_o`/`ram_wdata_o` carry the held address and data. They never carry the address of the incoming request. No RAM write occurs in the acceptance cycle itself.
- R5: A read accepted in cycle T whose address does not match the held write drives `ram_en_o`=1, `ram_we_o`=0 and `ram_addr_o` equal to the request address in cycle T. In cycle T+1, `rsp_valid_o` is 1 and `rsp_rdata_o` equals `ram_rdata_i`. At all other times `rsp_valid_o` is 0.
- R6: A read accepted while a write is held at the same address leaves `ram_en_o` at 0. Its response in T+1 carries the held data.
- R7: A read never commits the held write: `ram_we_o` stays 0 during a read. The held data is still returned, or committed, later.
- R8: If `flush_i` is 1 in an idle cycle while a write is held, then in the next cycle `busy_o`, `ram_en_o` and `ram_we_o` are 1 with the held address and data. After that cycle no write is held.
- R9: A flush while no write is held causes no RAM write and leaves `busy_o` at 0.
- R10: `req_ready_o` is 0 in every cycle in which `flush_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data, sampled one cycle after acceptance |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | DW | Read response data |
| flush_i | input | 1 | Commit the held write |
| busy_o | output | 1 | Flush commit in progress |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after a read access |

## Verification
The bench builds the block with AW=6 and DW=16. With only 64 addresses, random reads often land on the held address and random writes often overwrite an address that is already held. This exercises both the bypass path and back-to-back commits to the same location. During the acceptance cycle the bench drives unrelated data on the write data input, and during the capture cycle it drives an unrelated address. As a result, sampling the data in the wrong cycle, or committing the incoming address with the old data, produces a visible mismatch on the RAM port.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FLUSH = 2'd2
  } lwb_state_e;
endpackage

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
  import lwb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic flush_i,
  input  logic hold_valid_i,
  output logic ready_o,
  output logic wr_accept_o,
  output logic rd_accept_o,
  output logic commit_o,
  output logic load_o,
  output logic clear_o,
  output logic busy_o
);
  lwb_state_e state_q, state_d;

  assign ready_o     = (state_q == ST_IDLE) && !flush_i;
  assign wr_accept_o = req_valid_i && ready_o && req_we_i;
  assign rd_accept_o = req_valid_i && ready_o && !req_we_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_i && hold_valid_i) state_d = ST_FLUSH;
        else if (wr_accept_o)        state_d = ST_CAPT;
      end
      ST_CAPT:  state_d = ST_IDLE;
      ST_FLUSH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // the held write leaves in the capture cycle of its successor, or on flush
  assign commit_o = ((state_q == ST_CAPT) || (state_q == ST_FLUSH)) && hold_valid_i;
  assign load_o   = (state_q == ST_CAPT);
  assign clear_o  = (state_q == ST_FLUSH);
  assign busy_o   = (state_q == ST_FLUSH);
endmodule

// File: rtl/lwb_hold.sv
module lwb_hold #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_accept_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  input  logic          clear_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          hit_o
);
  logic [AW-1:0] pend_addr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          valid_q;
  logic [AW-1:0] bit_eq;

  // address of the write in flight, waiting for its late data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_addr_q <= '0;
    else if (wr_accept_i) pend_addr_q <= req_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= pend_addr_q;
      data_q  <= wdata_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < AW; i++) begin : g_cmp
    assign bit_eq[i] = ~(addr_q[i] ^ req_addr_i[i]);
  end

  assign hit_o   = valid_q && (&bit_eq);
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/lwb_port.sv
module lwb_port #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [AW-1:0] hold_addr_i,
  input  logic [DW-1:0] hold_data_i,
  input  logic          rd_accept_i,
  input  logic          rd_hit_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic          rsp_valid_q;
  logic          rsp_hit_q;
  logic [DW-1:0] hit_data_q;

  assign ram_we_o    = commit_i;
  assign ram_en_o    = commit_i || (rd_accept_i && !rd_hit_i);
  assign ram_addr_o  = commit_i ? hold_addr_i : req_addr_i;
  assign ram_wdata_o = hold_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      hit_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_accept_i;
      rsp_hit_q   <= rd_accept_i && rd_hit_i;
      if (rd_accept_i && rd_hit_i) hit_data_q <= hold_data_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_hit_q ? hit_data_q : ram_rdata_i;
endmodule

// File: rtl/late_write_buf.sv
module late_write_buf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic          flush_i,
  output logic          busy_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i
);
  logic          wr_accept, rd_accept, commit, load, clear;
  logic          hold_valid, hold_hit;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  lwb_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_we_i),
    .flush_i      (flush_i),
    .hold_valid_i (hold_valid),
    .ready_o      (req_ready_o),
    .wr_accept_o  (wr_accept),
    .rd_accept_o  (rd_accept),
    .commit_o     (commit),
    .load_o       (load),
    .clear_o      (clear),
    .busy_o       (busy_o)
  );

  lwb_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_accept_i (wr_accept),
    .req_addr_i  (req_addr_i),
    .wdata_i     (req_wdata_i),
    .load_i      (load),
    .clear_i     (clear),
    .valid_o     (hold_valid),
    .addr_o      (hold_addr),
    .data_o      (hold_data),
    .hit_o       (hold_hit)
  );

  lwb_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .hold_addr_i (hold_addr),
    .hold_data_i (hold_data),
    .rd_accept_i (rd_accept),
    .rd_hit_i    (hold_hit),
    .req_addr_i  (req_addr_i),
    .ram_rdata_i (ram_rdata_i),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/lwb_chk.sv
module lwb_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_we_i,
  input logic [AW-1:0] req_addr_i,
  input logic          rsp_valid_o,
  input logic          flush_i,
  input logic          busy_o,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o,
  input logic [DW-1:0] ram_wdata_o,
  input logic          hold_valid_i,
  input logic [AW-1:0] hold_addr_i,
  input logic [DW-1:0] hold_data_i
);
  logic wr_acc, rd_acc, rd_hit;
  assign wr_acc = req_valid_i && req_ready_o && req_we_i;
  assign rd_acc = req_valid_i && req_ready_o && !req_we_i;
  assign rd_hit = hold_valid_i && (req_addr_i == hold_addr_i);

  a_r1_rsp_only_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rd_acc));
  a_r2_ready_drops_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> !req_ready_o);
  a_r3_no_write_without_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> hold_valid_i);
  a_r4_commit_uses_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && hold_valid_i) |=> (ram_we_o && ram_addr_o == $past(hold_addr_i)
                                  && ram_wdata_o == $past(hold_data_i)));
  a_r4_no_write_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |-> !ram_we_o);
  a_r5_miss_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !rd_hit) |-> (ram_en_o && !ram_we_o && ram_addr_o == req_addr_i));
  a_r5_rsp_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rsp_valid_o);
  a_r6_hit_skips_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && rd_hit) |-> !ram_en_o);
  a_r7_read_keeps_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> (hold_valid_i == $past(hold_valid_i) && $stable(hold_addr_i)));
  a_r8_busy_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ram_en_o && ram_we_o));
  a_r8_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !hold_valid_i);
  a_r10_flush_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);
endmodule

bind late_write_buf lwb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_we_i     (req_we_i),
  .req_addr_i   (req_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .flush_i      (flush_i),
  .busy_o       (busy_o),
  .ram_en_o     (ram_en_o),
  .ram_we_o     (ram_we_o),
  .ram_addr_o   (ram_addr_o),
  .ram_wdata_o  (ram_wdata_o),
  .hold_valid_i (hold_valid),
  .hold_addr_i  (hold_addr),
  .hold_data_i  (hold_data)
);

// File: tb/tb_late_write_buf.sv
module tb_late_write_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0, flush = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, busy, ram_en, ram_we;
  logic [DW-1:0] rsp_rdata, ram_wdata;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_rdata = '0;

  logic [DW-1:0] ram_mem [NA];
  logic [DW-1:0] arch    [NA];
  logic          exp_hv = 1'b0;
  logic [AW-1:0] exp_ha = '0;
  logic [DW-1:0] exp_hd = '0;
  int            n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  late_write_buf #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .flush_i(flush), .busy_o(busy),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // behavioural RAM, synchronous read
  always @(posedge clk) begin
    if (ram_en && ram_we)  ram_mem[ram_addr] <= ram_wdata;
    if (ram_en && !ram_we) ram_rdata <= ram_mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = DW'($urandom);
    #1;
    chk(req_ready == 1'b1, "R2 ready at write", 32'(req_ready), 1);
    chk(ram_we == 1'b0, "R4 no write on accept", 32'(ram_we), 0);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = d; req_addr = AW'($urandom);
    #1;
    chk(req_ready == 1'b0, "R2 ready low in capture", 32'(req_ready), 0);
    chk(rsp_valid == 1'b0, "R5 no rsp on write", 32'(rsp_valid), 0);
    if (exp_hv) begin
      chk(ram_en && ram_we, "R4 commit strobe", 32'({ram_en, ram_we}), 3);
      chk(ram_addr == exp_ha, "R4 commit address", 32'(ram_addr), 32'(exp_ha));
      chk(ram_wdata == exp_hd, "R4 commit data", 32'(ram_wdata), 32'(exp_hd));
    end else begin
      chk(ram_we == 1'b0, "R3 first write silent", 32'(ram_we), 0);
    end
    arch[a] = d; exp_hv = 1'b1; exp_ha = a; exp_hd = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic hit;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wdata = DW'($urandom);
    #1;
    hit = exp_hv && (a == exp_ha);
    chk(ram_we == 1'b0, "R7 read never commits", 32'(ram_we), 0);
    if (hit) chk(ram_en == 1'b0, "R6 hit skips RAM", 32'(ram_en), 0);
    else begin
      chk(ram_en == 1'b1, "R5 miss enables RAM", 32'(ram_en), 1);
      chk(ram_addr == a, "R5 miss address", 32'(ram_addr), 32'(a));
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b1, "R5 rsp valid", 32'(rsp_valid), 1);
    chk(rsp_rdata == arch[a], hit ? "R6 hit data" : "R5 miss data", 32'(rsp_rdata), 32'(arch[a]));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_we = 1'b1; req_addr = AW'($urandom);
    #1;
    chk(req_ready == 1'b0, "R10 flush blocks request", 32'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    #1;
    if (exp_hv) begin
      chk(busy == 1'b1, "R8 busy during flush", 32'(busy), 1);
      chk(ram_we && ram_addr == exp_ha, "R8 flush address", 32'(ram_addr), 32'(exp_ha));
      chk(ram_wdata == exp_hd, "R8 flush data", 32'(ram_wdata), 32'(exp_hd));
      exp_hv = 1'b0;
    end else begin
      chk(busy == 1'b0 && ram_we == 1'b0, "R9 empty flush idle", 32'({busy, ram_we}), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251016));
    for (int i = 0; i < NA; i++) begin ram_mem[i] = '0; arch[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !ram_en && !rsp_valid && !busy, "R1 in reset",
        32'({req_ready, ram_en, rsp_valid, busy}), 32'h8);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(req_ready && !ram_en && !ram_we && !rsp_valid && !busy, "R1 after reset",
        32'({req_ready, ram_en, rsp_valid, busy}), 32'h8);

    // directed corners
    do_flush();                      // R9 nothing held
    do_write(6'd5, 16'h1111);        // R3 first write
    do_read(6'd5);                   // R6 hit
    do_read(6'd9);                   // R5 miss
    do_write(6'd7, 16'h2222);        // R4 commits addr 5
    do_read(6'd5);                   // R5 now from RAM
    do_write(6'd7, 16'h3333);        // same address back to back
    do_read(6'd7);                   // R6 newest value
    do_read(6'd7); do_read(6'd3);    // R7 reads leave hold alone
    do_flush();                      // R8
    do_read(6'd7);                   // R8 flushed value in RAM
    do_flush();                      // R9 after clear
    do_write(6'd0, 16'hFFFF);        // R3 after flush
    do_write(6'd63, 16'h0000);

    for (int n = 0; n < 600; n++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 10);
      a = (exp_hv && ($urandom % 3 == 0)) ? exp_ha : AW'($urandom);
      if (op < 4)       do_write(a, DW'($urandom));
      else if (op < 9)  do_read(a);
      else              do_flush();
    end

    do_flush();
    for (int i = 0; i < NA; i += 7) do_read(AW'(i));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule